// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block turns a stream of bytes into asynchronous serial frames. Bytes written on a one-byte-per-cycle port queue in a 128-entry first-in first-out buffer. The head of that buffer feeds an 8-bit shift register. The shift register sends a start bit, 5 to 8 data bits starting with the least significant bit, an optional parity bit and one, one-and-a-half or two stop bits. A single-cycle 16x enable, `tick_16x`, supplied from outside, paces every bit.

There are two status outputs. `fifo_empty` shows that no byte is waiting. `tx_idle` shows that nothing is waiting and no frame is on the line, so a driver can tell when the link may be turned around. When a frame ends and another byte is waiting, that byte is loaded in the same cycle, so back-to-back frames have no idle gap. The line format is captured when a byte is loaded and holds for the whole frame.

Top module: `fifo_serial_tx`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1 and `tx_idle` is 1.
- R2: A frame is a start bit of 0, then the data bits starting with bit 0, then a stop level of 1. The data bit count is 5, 6, 7 or 8 for `word_len` = 00, 01, 10, 11. Every start, data and parity bit lasts exactly 16 consumed `tick_16x` pulses.
- R3: When `parity_en` is 1, one parity bit follows the data bits. The parity bit is set by `parity_mode`: 00 makes the count of ones in the data bits plus the parity bit odd, 01 makes that count even, 10 sends 1, and 11 sends 0.
- R4: The stop level lasts 16 ticks when `two_stop` is 0. When `two_stop` is 1 it lasts 32 ticks, or 24 ticks with a 5-bit word.
- R5: While a frame is in progress, `txd` changes only on a clock edge that consumes a `tick_16x` pulse.
- R6: Bytes leave in the order they were accepted. The buffer holds 128 bytes in addition to the byte in the shift register.
- R7: A write while the buffer holds 128 bytes is dropped: it is never sent and does not disturb the bytes already held.
- R8: A byte accepted while the line is idle drives `txd` low one clock after it is accepted. When a byte is waiting at the end of a stop level, the next start bit begins on the very next tick period, with no idle gap.
- R9: `fifo_empty` is 1 whenever no byte is waiting, including while the last byte is being shifted. `tx_idle` is 1 only when no byte is waiting and no frame is in progress. `tx_idle` rises on the clock edge that ends the final stop level.
- R10: `word_len`, `parity_en`, `parity_mode` and `two_stop` are sampled when a byte is loaded. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| word_len | input | 2 | Data bit count select (5 to 8) |
| parity_en | input | 1 | Insert a parity bit |
| parity_mode | input | 2 | Parity kind: odd, even, forced 1, forced 0 |
| two_stop | input | 1 | Long stop level (2 bits, or 1.5 with a 5-bit word) |
| tick_16x | input | 1 | One-cycle 16x bit-rate enable |
| txd | output | 1 | Serial output, idles at 1 |
| fifo_empty | output | 1 | No byte waiting in the buffer |
| tx_idle | output | 1 | Buffer empty and no frame in progress |

## Verification
A write is accepted on the edge that samples `wr_en`. When the line is idle, the byte is loaded on the following edge, so the bench expects `txd` low and `fifo_empty` high at the second falling edge after it raises `wr_en`. After that, every level on the line is counted in ticks rather than clocks. The bench drives `tick_16x` one nanosecond after a rising edge. On each falling edge it samples `txd` and counts the tick that the next rising edge will consume. It moves to the next expected bit only once the required number of ticks for the current bit has been seen. This tracking runs without re-synchronising across back-to-back frames, so an idle cycle between frames shows up as a mismatch. The bench checks `tx_idle` at the falling edge that follows the rising edge which consumed the final stop tick.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;      // 00..11 -> 5..8 data bits
    logic       par_en;
    logic [1:0] par_mode;  // 00 odd, 01 even, 10 one, 11 zero
    logic       two_stop;
  } line_fmt_t;

  // Number of data bits for a word length code.
  function automatic logic [3:0] data_bits(input logic [1:0] wlen);
    return 4'd5 + {2'b00, wlen};
  endfunction

  // Parity bit value for the active data bits of a byte.
  function automatic logic parity_of(input logic [7:0] d,
                                     input logic [1:0] wlen,
                                     input logic [1:0] mode);
    logic [7:0] mask;
    logic       x;
    mask = 8'hFF >> (2'd3 - wlen);
    x    = ^(d & mask);
    case (mode)
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Length of the stop level in ticks.
  function automatic int unsigned stop_len(input logic two_stop,
                                           input logic [1:0] wlen,
                                           input int unsigned tpb);
    if (!two_stop)         return tpb;
    else if (wlen == 2'b00) return tpb + tpb / 2;
    else                   return 2 * tpb;
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [W-1:0]                   wr_data,
  input  logic                           rd_en,
  output logic [W-1:0]                   rd_data,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      have_data,
  input  logic [7:0] next_byte,
  input  line_fmt_t fmt,
  output logic      load,
  output logic      txd,
  output logic      busy,
  output logic      frame_done
);
  localparam int CNT_W = $clog2(2 * TPB + 1);

  tx_state_e      state;
  logic [7:0]     shreg;
  logic [3:0]     bits_left;
  logic [CNT_W-1:0] tick_cnt;
  line_fmt_t      fmt_q;
  logic           par_q;
  logic [CNT_W-1:0] seg_len;
  logic           seg_end;

  assign seg_len    = (state == ST_STOP)
                      ? CNT_W'(stop_len(fmt_q.two_stop, fmt_q.wlen, TPB))
                      : CNT_W'(TPB);
  assign seg_end    = tick && (tick_cnt == seg_len - 1'b1);
  assign frame_done = (state == ST_STOP) && seg_end;
  assign load       = have_data && ((state == ST_IDLE) || frame_done);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    case (state)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg[0];
      ST_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      shreg     <= '0;
      bits_left <= '0;
      tick_cnt  <= '0;
      fmt_q     <= '0;
      par_q     <= 1'b0;
    end else if (load) begin
      state    <= ST_START;
      shreg    <= next_byte;
      fmt_q    <= fmt;
      par_q    <= parity_of(next_byte, fmt.wlen, fmt.par_mode);
      tick_cnt <= '0;
    end else if (busy && tick) begin
      if (!seg_end) begin
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        tick_cnt <= '0;
        case (state)
          ST_START: begin
            state     <= ST_DATA;
            bits_left <= data_bits(fmt_q.wlen) - 4'd1;
          end
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bits_left == '0) state <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                 bits_left <= bits_left - 4'd1;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/fifo_serial_tx.sv
module fifo_serial_tx
  import sertx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int TPB   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] word_len,
  input  logic       parity_en,
  input  logic [1:0] parity_mode,
  input  logic       two_stop,
  input  logic       tick_16x,
  output logic       txd,
  output logic       fifo_empty,
  output logic       tx_idle
);
  localparam int CW = $clog2(DEPTH + 1);

  line_fmt_t     fmt_in;
  logic [7:0]    head_byte;
  logic          fifo_full_w;
  logic          fifo_pop_w;
  logic [CW-1:0] fifo_count_w;
  logic          busy_w;
  logic          frame_done_w;

  assign fmt_in = '{wlen: word_len, par_en: parity_en,
                    par_mode: parity_mode, two_stop: two_stop};

  sertx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (fifo_pop_w),
    .rd_data (head_byte),
    .empty   (fifo_empty),
    .full    (fifo_full_w),
    .count   (fifo_count_w)
  );

  sertx_shifter #(.TPB(TPB)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_16x),
    .have_data  (!fifo_empty),
    .next_byte  (head_byte),
    .fmt        (fmt_in),
    .load       (fifo_pop_w),
    .txd        (txd),
    .busy       (busy_w),
    .frame_done (frame_done_w)
  );

  assign tx_idle = fifo_empty && !busy_w;
endmodule

// File: rtl/fifo_serial_tx_chk.sv
module fifo_serial_tx_chk #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          tick_16x,
  input logic          txd,
  input logic          fifo_empty,
  input logic          tx_idle,
  input logic          fifo_full,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_count,
  input logic          busy,
  input logic          frame_done
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

  // R9
  idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> fifo_empty);

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  // R5
  no_tick_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_16x) |=> $stable(txd));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R7
  full_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_en && !fifo_pop) |=> (fifo_count == $past(fifo_count)));

  // R8
  gapless_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !fifo_empty) |-> fifo_pop);
endmodule

bind fifo_serial_tx fifo_serial_tx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .tick_16x   (tick_16x),
  .txd        (txd),
  .fifo_empty (fifo_empty),
  .tx_idle    (tx_idle),
  .fifo_full  (fifo_full_w),
  .fifo_pop   (fifo_pop_w),
  .fifo_count (fifo_count_w),
  .busy       (busy_w),
  .frame_done (frame_done_w)
);

// File: tb/fifo_serial_tx_bench.sv
`timescale 1ns/100ps
module fifo_serial_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = 2'b11;
  logic       parity_en = 1'b0;
  logic [1:0] parity_mode = 2'b00;
  logic       two_stop = 1'b0;
  logic       tick_16x = 1'b0;
  logic       txd, fifo_empty, tx_idle;

  logic tick_on = 1'b0;
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  fifo_serial_tx u_fifo_serial_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .word_len(word_len), .parity_en(parity_en), .parity_mode(parity_mode),
    .two_stop(two_stop), .tick_16x(tick_16x), .txd(txd),
    .fifo_empty(fifo_empty), .tx_idle(tx_idle)
  );

  // tick every second clock, driven just after the rising edge
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #1;
      tick_16x = tick_on && (div == 0);
      div = (div + 1) % 2;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_fmt(input logic [1:0] wl, input logic pe,
                         input logic [1:0] pm, input logic ts);
    word_len = wl; parity_en = pe; parity_mode = pm; two_stop = ts;
  endtask

  task automatic write_bytes(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = first + 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Follow one frame tick by tick; first=1 waits for the start bit.
  task automatic expect_frame(input logic [7:0] d, input logic [1:0] wl,
                              input logic pe, input logic [1:0] pm,
                              input logic ts, input bit first, input string tag);
    logic vals[12];
    int   durs[12];
    int   nseg, nb, ones, seg, cnt, bad, bad_seg, found;
    logic bad_val;
    nb = 5 + int'(wl);
    vals[0] = 1'b0; durs[0] = 16;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      vals[1 + i] = d[i]; durs[1 + i] = 16;
      ones += int'(d[i]);
    end
    nseg = 1 + nb;
    if (pe) begin
      case (pm)
        2'b00: vals[nseg] = (ones % 2 == 0);
        2'b01: vals[nseg] = (ones % 2 == 1);
        2'b10: vals[nseg] = 1'b1;
        default: vals[nseg] = 1'b0;
      endcase
      durs[nseg] = 16; nseg++;
    end
    vals[nseg] = 1'b1;
    durs[nseg] = !ts ? 16 : (nb == 5 ? 24 : 32);
    nseg++;
    @(negedge clk);
    if (first) begin
      found = 0;
      for (int k = 0; k < 4000 && !found; k++) begin
        if (txd == 1'b0) found = 1;
        else @(negedge clk);
      end
      if (!found) begin
        check(1'b0, {tag, " start bit never seen"}, 1, 0);
        return;
      end
    end
    seg = 0; cnt = 0; bad = 0; bad_seg = 0; bad_val = 1'b0;
    forever begin
      if (txd !== vals[seg] && bad == 0) begin
        bad = 1; bad_seg = seg; bad_val = txd;
      end
      if (tick_16x) cnt++;
      if (cnt == durs[seg]) begin
        seg++; cnt = 0;
      end
      if (seg == nseg) break;
      @(negedge clk);
    end
    check(bad == 0, $sformatf("%s frame %02h bit %0d", tag, d, bad_seg),
          int'(bad_val), int'(vals[bad_seg]));
  endtask

  task automatic t_reset();
    check(txd == 1'b1, "R1 txd", int'(txd), 1);
    check(fifo_empty == 1'b1, "R1 fifo_empty", int'(fifo_empty), 1);
    check(tx_idle == 1'b1, "R1 tx_idle", int'(tx_idle), 1);
  endtask

  task automatic one_frame(input logic [7:0] d, input logic [1:0] wl,
                           input logic pe, input logic [1:0] pm,
                           input logic ts, input string tag);
    set_fmt(wl, pe, pm, ts);
    write_bytes(d, 1);
    expect_frame(d, wl, pe, pm, ts, 1'b1, tag);
    @(negedge clk);
    check(tx_idle == 1'b1, {tag, " R9 idle after stop"}, int'(tx_idle), 1);
  endtask

  task automatic t_formats();
    tick_on = 1'b1;
    one_frame(8'hA5, 2'b11, 1'b0, 2'b00, 1'b0, "R2 8N1");
    one_frame(8'h13, 2'b00, 1'b1, 2'b01, 1'b1, "R3 R4 5E1.5");
    one_frame(8'h6C, 2'b10, 1'b1, 2'b00, 1'b1, "R3 R4 7O2");
    one_frame(8'h2B, 2'b01, 1'b1, 2'b10, 1'b0, "R3 6M1");
    one_frame(8'hFF, 2'b11, 1'b1, 2'b11, 1'b1, "R3 R4 8S2");
    one_frame(8'h01, 2'b11, 1'b1, 2'b00, 1'b0, "R3 8O1");
  endtask

  task automatic t_latency();
    set_fmt(2'b11, 1'b0, 2'b00, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0;
    check(txd == 1'b1, "R8 txd before load", int'(txd), 1);
    check(fifo_empty == 1'b0, "R9 byte waiting", int'(fifo_empty), 0);
    @(negedge clk);
    check(txd == 1'b0, "R8 start one clock after accept", int'(txd), 0);
    check(fifo_empty == 1'b1 && tx_idle == 1'b0, "R9 shifting last byte",
          int'({fifo_empty, tx_idle}), 2);
    for (int k = 0; k < 2000 && !tx_idle; k++) @(negedge clk);
    check(tx_idle == 1'b1, "R9 idle after latency frame", int'(tx_idle), 1);
  endtask

  task automatic t_hold();
    bit moved;
    tick_on = 1'b0;
    repeat (3) @(negedge clk);
    set_fmt(2'b11, 1'b0, 2'b00, 1'b0);
    write_bytes(8'hC3, 1);
    moved = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (txd !== 1'b0) moved = 1'b1;
      if (k == 5) set_fmt(2'b00, 1'b1, 2'b10, 1'b1);
    end
    check(!moved, "R5 line frozen without ticks", int'(moved), 0);
    check(tx_idle == 1'b0, "R9 busy while frozen", int'(tx_idle), 0);
    tick_on = 1'b1;
    expect_frame(8'hC3, 2'b11, 1'b0, 2'b00, 1'b0, 1'b1, "R10 format latched");
    @(negedge clk);
    check(tx_idle == 1'b1, "R9 idle after hold", int'(tx_idle), 1);
  endtask

  task automatic t_fill();
    bit quiet;
    tick_on = 1'b0;
    set_fmt(2'b11, 1'b0, 2'b00, 1'b0);
    repeat (3) @(negedge clk);
    write_bytes(8'h00, 129);
    write_bytes(8'hEE, 2);
    check(fifo_empty == 1'b0, "R6 full buffer not empty", int'(fifo_empty), 0);
    tick_on = 1'b1;
    for (int i = 0; i < 129; i++)
      expect_frame(8'(i), 2'b11, 1'b0, 2'b00, 1'b0, (i == 0),
                   $sformatf("R6 R8 burst %0d", i));
    @(negedge clk);
    check(tx_idle == 1'b1 && fifo_empty == 1'b1, "R9 idle after burst",
          int'({tx_idle, fifo_empty}), 3);
    quiet = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 1'b0;
    end
    check(quiet, "R7 dropped writes never sent", int'(quiet), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_formats();
    t_latency();
    t_hold();
    t_fill();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule